// File: doc/BRIEF.md
# CLOCK Replacement Victim Selector

This block picks which physical frame to evict when memory is full. It keeps a one-bit "recently used" flag for every frame and a rotating hand. Each time a frame is used, the memory system reports the frame's number and that frame's flag is raised.

When a victim is requested, the hand steps around the ring of frames one per clock cycle. Every raised flag it meets is lowered, which gives that frame a second chance. It stops at the first frame whose flag is already low. That frame is reported as the victim with a single-cycle valid pulse. The hand is then parked on the frame after the victim, so the next search continues from there rather than from frame zero.

A request is taken only while the selector is idle. While a search is in progress the ready output is low, and a request made in that time is not stored. Frame count is a parameter.

Top module: `clock_victim_picker`

## Requirements
- R1: After reset every used flag is low, the hand is at frame 0, `busy` and `victim_valid` are low and `req_ready` is high.
- R2: A cycle with `touch_valid` high raises the used flag of frame `touch_frame` at the next clock edge.
- R3: A request accepted at an edge (`req_valid` and `req_ready` both high) starts a search at the hand. The first frame with a low flag is reported on `victim_frame` with `victim_valid` high for exactly one cycle, and `busy` is low in that cycle.
- R4: Every frame the search passes over because its flag was high has that flag lowered.
- R5: After a victim is reported, the hand points at the frame numbered one above the victim, wrapping from NFRAMES-1 to 0.
- R6: One frame is examined per clock edge. When the victim lies k frames past the hand (k = 0 .. NFRAMES-1), `victim_valid` rises k+1 edges after the accepting edge. When every flag is high and no frame is used during the search, the search takes NFRAMES+1 edges and the victim is the frame at the hand.
- R7: When a frame is reported used in the same cycle that the search lowers its flag, the flag ends high.
- R8: While a search runs, `busy` is high and `req_ready` is low. A request held during that time is neither accepted nor remembered, so no second victim follows.
- R9: The victim's flag stays low after selection, unless the frame is reported used, which raises it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| touch_valid | input | 1 | A frame was used this cycle |
| touch_frame | input | $clog2(NFRAMES) | Number of the used frame |
| req_valid | input | 1 | Request for a victim |
| req_ready | output | 1 | High when a request can be taken |
| busy | output | 1 | Search in progress |
| victim_valid | output | 1 | One-cycle pulse marking the chosen frame |
| victim_frame | output | $clog2(NFRAMES) | Chosen frame, valid with `victim_valid` |

## Verification
The bench loads all 256 flag patterns of an eight-frame ring, one after another, without resetting in between, so the hand arrives at each pattern from many different positions. For each pattern it checks the chosen frame and the exact search length against a search model computed in the bench:
- A selector that always restarted at frame 0 would pick the wrong victim.
- One that failed to lower passed-over flags would repeat victims.
- One that was off by one on the hand would skip a frame.

Other targeted cases cover:
- The all-high ring, which needs NFRAMES+1 cycles. A sloppy bound would either hang or pick a frame whose flag is high.
- A use report that lands on the frame being lowered. A design that lets the lowering win would later evict that frame too early.
- A request held while busy. A design that queued it would emit a second victim.
- Reset in the middle of operation, which must return the hand to frame 0.

// File: rtl/clock_victim_picker.sv
module clock_victim_picker #(
  parameter int NFRAMES = 8,
  localparam int IW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_valid,
  input  logic [IW-1:0] touch_frame,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          busy,
  output logic          victim_valid,
  output logic [IW-1:0] victim_frame
);

  localparam logic [IW-1:0] LAST = IW'(NFRAMES - 1);

  logic [NFRAMES-1:0] ref_q;
  logic [IW-1:0]      hand_q, scan_q, vf_q;
  logic               busy_q, vv_q;

  wire          accept   = req_valid && !busy_q;
  wire [IW-1:0] scan_nxt = (scan_q == LAST) ? '0 : scan_q + 1'b1;
  wire          scan_hit = busy_q && !ref_q[scan_q];

  for (genvar i = 0; i < NFRAMES; i++) begin : g_ref
    wire set_i = touch_valid && (touch_frame == IW'(i));
    wire clr_i = busy_q && (scan_q == IW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)     ref_q[i] <= 1'b0;
      else if (set_i) ref_q[i] <= 1'b1;
      else if (clr_i) ref_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hand_q <= '0;
      scan_q <= '0;
      vv_q   <= 1'b0;
      vf_q   <= '0;
    end else begin
      vv_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        scan_q <= hand_q;
      end else if (scan_hit) begin
        busy_q <= 1'b0;
        hand_q <= scan_nxt;
        vv_q   <= 1'b1;
        vf_q   <= scan_q;
      end else if (busy_q) begin
        scan_q <= scan_nxt;
      end
    end
  end

  assign req_ready    = !busy_q;
  assign busy         = busy_q;
  assign victim_valid = vv_q;
  assign victim_frame = vf_q;

endmodule

// File: rtl/clock_victim_picker_chk.sv
module clock_victim_picker_chk #(
  parameter int NFRAMES = 8,
  localparam int IW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               touch_valid,
  input logic [IW-1:0]      touch_frame,
  input logic               req_valid,
  input logic               req_ready,
  input logic               busy,
  input logic               victim_valid,
  input logic [IW-1:0]      victim_frame,
  input logic [NFRAMES-1:0] ref_q,
  input logic [IW-1:0]      hand_q
);

  int  span_q;
  logic touched_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      span_q    <= 0;
      touched_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      span_q    <= 0;
      touched_q <= touch_valid;
    end else if (busy) begin
      span_q    <= span_q + 1;
      touched_q <= touched_q || touch_valid;
    end
  end

  wire [IW-1:0] after_victim = (victim_frame == IW'(NFRAMES - 1)) ? '0 : victim_frame + 1'b1;

  AST_READY_LOW_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !req_ready); // R8
  AST_TOUCH_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (touch_valid && touch_frame < IW'(NFRAMES)) |=> ref_q[$past(touch_frame)]); // R2
  AST_HAND_PAST_VICTIM: assert property (@(posedge clk) disable iff (!rst_n) victim_valid |-> hand_q == after_victim); // R5
  AST_VICTIM_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n) (victim_valid && !($past(touch_valid) && $past(touch_frame) == victim_frame)) |-> !ref_q[victim_frame]); // R9
  AST_VICTIM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) victim_valid |=> !victim_valid); // R3
  AST_IDLE_WITH_VICTIM: assert property (@(posedge clk) disable iff (!rst_n) victim_valid |-> !busy); // R3
  AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (busy && !touched_q) |-> span_q <= NFRAMES); // R6

endmodule

bind clock_victim_picker clock_victim_picker_chk #(.NFRAMES(NFRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid), .touch_frame(touch_frame),
  .req_valid(req_valid), .req_ready(req_ready), .busy(busy),
  .victim_valid(victim_valid), .victim_frame(victim_frame),
  .ref_q(ref_q), .hand_q(hand_q)
);

// File: tb/clock_victim_picker_test.sv
`timescale 1ns/1ps
module clock_victim_picker_test;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic touch_valid = 1'b0, req_valid = 1'b0;
  logic [IW-1:0] touch_frame = '0;
  logic req_ready, busy, victim_valid;
  logic [IW-1:0] victim_frame;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [N-1:0] mref = '0;
  int mhand = 0;

  clock_victim_picker #(.NFRAMES(N)) uut (
    .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid), .touch_frame(touch_frame),
    .req_valid(req_valid), .req_ready(req_ready), .busy(busy),
    .victim_valid(victim_valid), .victim_frame(victim_frame)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    mref = '0; mhand = 0;
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(victim_valid == 1'b0, "R1 victim_valid", victim_valid, 0);
    check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
  endtask

  task automatic touch(input int f);
    touch_valid = 1'b1; touch_frame = IW'(f);
    @(negedge clk);
    touch_valid = 1'b0;
    mref[f] = 1'b1;
  endtask

  task automatic do_req(input int inj_at, input int inj_frame, input bit hold, input string tag);
    int exp_v, exp_m, m;
    bit got;
    exp_v = mhand; exp_m = N + 1;
    for (int k = 0; k < N; k++) begin
      if (!mref[(mhand + k) % N]) begin exp_v = (mhand + k) % N; exp_m = k + 1; break; end
    end
    for (int k = 0; k < exp_m - 1; k++) mref[(mhand + k) % N] = 1'b0;
    if (inj_at >= 0) mref[inj_frame] = 1'b1;
    check(req_ready == 1'b1, {tag, " ready before request"}, req_ready, 1);
    req_valid = 1'b1;
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    m = 0; got = 0;
    while (m < N + 4 && !got) begin
      if (hold) check(req_ready == 1'b0 && busy == 1'b1, "R8 not ready while busy", req_ready, 0);
      if (m == inj_at) begin touch_valid = 1'b1; touch_frame = IW'(inj_frame); end
      @(negedge clk);
      touch_valid = 1'b0;
      m++;
      if (victim_valid) got = 1;
    end
    req_valid = 1'b0;
    check(got, {tag, " victim seen"}, got, 1);
    check(victim_frame == IW'(exp_v), {tag, " victim frame"}, victim_frame, exp_v);
    check(m == exp_m, "R6 search length", m, exp_m);
    check(busy == 1'b0, "R3 idle with victim", busy, 0);
    @(negedge clk);
    check(victim_valid == 1'b0, "R3 single pulse", victim_valid, 0);
    if (hold) begin
      @(negedge clk); @(negedge clk);
      check(victim_valid == 1'b0 && busy == 1'b0, "R8 held request not queued", busy, 0);
    end
    mhand = (exp_v + 1) % N;
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    do_req(-1, 0, 0, "R1 hand at zero");
    do_req(-1, 0, 0, "R5 next frame");
    for (int f = 0; f < N; f++) touch(f);
    do_req(-1, 0, 0, "R6 all set");
    do_req(-1, 0, 0, "R4 flags cleared");

    do_reset();
    for (int f = 0; f < N; f++) touch(f);
    do_req(3, 3, 0, "R7 collision sweep");
    do_req(-1, 0, 0, "R7 follow a");
    do_req(-1, 0, 0, "R7 follow b");
    do_req(-1, 0, 0, "R7 set wins");

    do_req(-1, 0, 0, "R9 pick");
    touch((mhand + N - 1) % N);
    for (int f = 0; f < N; f++) if (f != (mhand + N - 1) % N) touch(f);
    do_req(-1, 0, 0, "R9 retouched victim");
    do_req(-1, 0, 1, "R8 held request");

    for (int p = 0; p < 256; p++) begin
      for (int f = 0; f < N; f++) if (p[f]) touch(f);
      do_req(-1, 0, 0, "R3 pattern sweep");
    end

    touch(2); touch(5);
    do_reset();
    do_req(-1, 0, 0, "R1 after reset");
    do_req(-1, 0, 0, "R2 after reset");
    touch(2); touch(3);
    do_req(-1, 0, 0, "R2 touched frames skipped");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule